// File: doc/BRIEF.md
# Direct-Mapped Word Cache Controller

This block sits between a processor and a slower main memory. It holds recently used words of a 32K-word space of 12-bit words in a 512-entry store. Each entry has a tag, a data word and a valid flag. A processor request carries a 15-bit address. The controller splits that address into a 9-bit index and a 6-bit tag. The index selects one entry, and the tag is compared against the tag stored in that entry. A read that hits is answered from the store without touching main memory. A read that misses fetches the word through a request/acknowledge memory port, forwards it, and installs it with its tag.

All writes go straight through to main memory. A write that hits also refreshes the cached copy. A write that misses leaves the store alone. The valid flags are cleared by reset and by a one-cycle initialise strobe, so an empty entry never produces a hit. Two free-running counters expose the number of hit and miss lookups, from which the hit ratio follows.

Top module: `dm_cache`

## Requirements
- R1: After reset, `cpu_ready_o` is 1, `cpu_valid_o` and `mem_req_o` are 0, and both event counters read 0.
- R2: The index is address bits [8:0] and the tag is bits [14:9]. Two addresses with the same index and different tags occupy the same entry, so each evicts the other.
- R3: A read hit returns the stored word with `cpu_valid_o` high exactly 2 cycles after the accepting clock edge, and issues no main-memory request.
- R4: A read miss issues a memory read (`mem_we_o`=0) at the requested address and returns the word `mem_rdata_i` with `cpu_valid_o` in the cycle after `mem_ack_i`. It also installs the word, so a repeat read of that address hits.
- R5: Every write issues a memory write carrying the request's address and data, whether it hits or misses. `cpu_valid_o` pulses in the cycle after `mem_ack_i`.
- R6: A write that hits updates the cached word, so the next read of that address hits and returns the new data.
- R7: A write that misses does not allocate an entry, so a following read of that address misses.
- R8: A one-cycle `init_i` pulse clears every valid flag, so each later first access to any address misses.
- R9: `cpu_ready_o` is low from the accepting edge until the `cpu_valid_o` pulse, which lasts one cycle. While `mem_req_o` waits for `mem_ack_i`, the request, its address and its direction stay stable.
- R10: `hit_cnt_o` increases by one for each lookup that hits. `miss_cnt_o` increases by one for each lookup that misses, reads and writes alike.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| init_i | input | 1 | Clears all valid flags |
| cpu_req_i | input | 1 | Access request, taken while ready is high |
| cpu_we_i | input | 1 | 1 = write, 0 = read |
| cpu_addr_i | input | 15 | Word address |
| cpu_wdata_i | input | 12 | Write data |
| cpu_ready_o | output | 1 | Controller idle, can accept a request |
| cpu_valid_o | output | 1 | One-cycle completion pulse |
| cpu_rdata_o | output | 12 | Read result, valid with cpu_valid_o |
| mem_req_o | output | 1 | Main-memory request, held until ack |
| mem_we_o | output | 1 | Main-memory direction, 1 = write |
| mem_addr_o | output | 15 | Main-memory word address |
| mem_wdata_o | output | 12 | Main-memory write data |
| mem_ack_i | input | 1 | Main-memory completion strobe |
| mem_rdata_i | input | 12 | Main-memory read data, valid with ack |
| hit_cnt_o | output | 16 | Hit lookup count |
| miss_cnt_o | output | 16 | Miss lookup count |

## Verification
A read hit completes in a fixed 2 cycles: one lookup cycle and one response cycle after the accepting edge. The bench counts falling edges from acceptance and requires the completion pulse on the second one. Misses and writes take a variable time, because the bench's memory model acknowledges after a latency of 0 to 3 cycles that changes with the address. For those, completion is expected in the cycle after the acknowledge, and the bench waits for the pulse instead of assuming a count. Event counters and memory traffic counts are sampled on the falling edge where the pulse is seen. The counters have already updated one edge after acceptance, so their values are settled by then.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
  localparam int unsigned ADDR_W_DEF = 15;
  localparam int unsigned DATA_W_DEF = 12;
  localparam int unsigned IDX_W_DEF  = 9;
  localparam int unsigned CNT_W_DEF  = 16;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_MEM_RD,
    ST_MEM_WR,
    ST_RESP
  } dmc_state_e;
endpackage

// File: rtl/dmc_store.sv
module dmc_store #(
  parameter int unsigned IDX_W  = 9,
  parameter int unsigned TAG_W  = 6,
  parameter int unsigned DATA_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              init_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic              rd_valid_o,
  output logic [TAG_W-1:0]  rd_tag_o,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [TAG_W-1:0]  wr_tag_i,
  input  logic [DATA_W-1:0] wr_data_i
);
  localparam int unsigned DEPTH = 1 << IDX_W;

  logic [DEPTH-1:0]  valid_q;
  logic [TAG_W-1:0]  tag_mem  [DEPTH];
  logic [DATA_W-1:0] data_mem [DEPTH];

  // init wins over a same-cycle fill
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      valid_q <= '0;
    else if (init_i)  valid_q <= '0;
    else if (wr_en_i) valid_q[wr_idx_i] <= 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      tag_mem[wr_idx_i]  <= wr_tag_i;
      data_mem[wr_idx_i] <= wr_data_i;
    end
  end

  assign rd_valid_o = valid_q[rd_idx_i];
  assign rd_tag_o   = tag_mem[rd_idx_i];
  assign rd_data_o  = data_mem[rd_idx_i];

  p_init_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_i |=> (valid_q == '0));

  p_fill_valid_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !init_i) |=> valid_q[$past(wr_idx_i)]);
endmodule

// File: rtl/dmc_ctrl.sv
module dmc_ctrl
  import dmc_pkg::*;
#(
  parameter int unsigned ADDR_W = 15,
  parameter int unsigned DATA_W = 12,
  parameter int unsigned IDX_W  = 9,
  localparam int unsigned TAG_W = ADDR_W - IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic              cpu_ready_o,
  output logic              cpu_valid_o,
  output logic [DATA_W-1:0] cpu_rdata_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [IDX_W-1:0]  rd_idx_o,
  input  logic              rd_valid_i,
  input  logic [TAG_W-1:0]  rd_tag_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              wr_en_o,
  output logic [IDX_W-1:0]  wr_idx_o,
  output logic [TAG_W-1:0]  wr_tag_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              hit_evt_o,
  output logic              miss_evt_o
);
  dmc_state_e        state_q;
  logic [ADDR_W-1:0] addr_q;
  logic              we_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;

  logic [TAG_W-1:0]  tag_s;
  logic [IDX_W-1:0]  idx_s;
  logic              lookup_s;
  logic              hit_s;

  assign tag_s    = addr_q[ADDR_W-1:IDX_W];
  assign idx_s    = addr_q[IDX_W-1:0];
  assign lookup_s = (state_q == ST_LOOKUP);
  assign hit_s    = rd_valid_i && (rd_tag_i == tag_s);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      we_q    <= 1'b0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (cpu_req_i) begin
          addr_q  <= cpu_addr_i;
          we_q    <= cpu_we_i;
          wdata_q <= cpu_wdata_i;
          state_q <= ST_LOOKUP;
        end
        ST_LOOKUP: begin
          if (we_q) state_q <= ST_MEM_WR;
          else if (hit_s) begin
            rdata_q <= rd_data_i;
            state_q <= ST_RESP;
          end else state_q <= ST_MEM_RD;
        end
        ST_MEM_RD: if (mem_ack_i) begin
          rdata_q <= mem_rdata_i;
          state_q <= ST_RESP;
        end
        ST_MEM_WR: if (mem_ack_i) state_q <= ST_RESP;
        ST_RESP:   state_q <= ST_IDLE;
        default:   state_q <= ST_IDLE;
      endcase
    end
  end

  // store write: write hit refresh, or miss fill on ack
  assign wr_en_o   = (lookup_s && we_q && hit_s) || (state_q == ST_MEM_RD && mem_ack_i);
  assign wr_idx_o  = idx_s;
  assign wr_tag_o  = tag_s;
  assign wr_data_o = (state_q == ST_MEM_RD) ? mem_rdata_i : wdata_q;
  assign rd_idx_o  = idx_s;

  assign hit_evt_o  = lookup_s && hit_s;
  assign miss_evt_o = lookup_s && !hit_s;

  assign mem_req_o   = (state_q == ST_MEM_RD) || (state_q == ST_MEM_WR);
  assign mem_we_o    = (state_q == ST_MEM_WR);
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = wdata_q;

  assign cpu_ready_o = (state_q == ST_IDLE);
  assign cpu_valid_o = (state_q == ST_RESP);
  assign cpu_rdata_o = rdata_q;

  p_read_hit_fast_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lookup_s && hit_s && !we_q) |=> (cpu_valid_o && !mem_req_o));

  p_resp_after_ack_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_ack_i) |=> cpu_valid_o);

  p_write_through_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lookup_s && we_q) |=> (mem_req_o && mem_we_o));

  p_mem_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));

  p_valid_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_valid_o |=> (!cpu_valid_o && cpu_ready_o));
endmodule

// File: rtl/dmc_stats.sv
module dmc_stats #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hit_evt_i,
  input  logic             miss_evt_i,
  output logic [CNT_W-1:0] hit_cnt_o,
  output logic [CNT_W-1:0] miss_cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_cnt_o  <= '0;
      miss_cnt_o <= '0;
    end else begin
      if (hit_evt_i)  hit_cnt_o  <= hit_cnt_o + 1'b1;
      if (miss_evt_i) miss_cnt_o <= miss_cnt_o + 1'b1;
    end
  end

  p_one_event_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({hit_evt_i, miss_evt_i}));

  p_idle_counts_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hit_evt_i && !miss_evt_i) |=> ($stable(hit_cnt_o) && $stable(miss_cnt_o)));
endmodule

// File: rtl/dm_cache.sv
module dm_cache
  import dmc_pkg::*;
#(
  parameter int unsigned ADDR_W = ADDR_W_DEF,
  parameter int unsigned DATA_W = DATA_W_DEF,
  parameter int unsigned IDX_W  = IDX_W_DEF,
  parameter int unsigned CNT_W  = CNT_W_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              init_i,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic              cpu_ready_o,
  output logic              cpu_valid_o,
  output logic [DATA_W-1:0] cpu_rdata_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [CNT_W-1:0]  hit_cnt_o,
  output logic [CNT_W-1:0]  miss_cnt_o
);
  localparam int unsigned TAG_W = ADDR_W - IDX_W;

  logic [IDX_W-1:0]  rd_idx;
  logic              rd_valid;
  logic [TAG_W-1:0]  rd_tag;
  logic [DATA_W-1:0] rd_data;
  logic              wr_en;
  logic [IDX_W-1:0]  wr_idx;
  logic [TAG_W-1:0]  wr_tag;
  logic [DATA_W-1:0] wr_data;
  logic              hit_evt;
  logic              miss_evt;

  dmc_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_ctrl (
    .clk_i, .rst_ni,
    .cpu_req_i, .cpu_we_i, .cpu_addr_i, .cpu_wdata_i,
    .cpu_ready_o, .cpu_valid_o, .cpu_rdata_o,
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o, .mem_ack_i, .mem_rdata_i,
    .rd_idx_o(rd_idx), .rd_valid_i(rd_valid), .rd_tag_i(rd_tag), .rd_data_i(rd_data),
    .wr_en_o(wr_en), .wr_idx_o(wr_idx), .wr_tag_o(wr_tag), .wr_data_o(wr_data),
    .hit_evt_o(hit_evt), .miss_evt_o(miss_evt)
  );

  dmc_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
    .clk_i, .rst_ni, .init_i,
    .rd_idx_i(rd_idx), .rd_valid_o(rd_valid), .rd_tag_o(rd_tag), .rd_data_o(rd_data),
    .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_tag_i(wr_tag), .wr_data_i(wr_data)
  );

  dmc_stats #(.CNT_W(CNT_W)) u_stats (
    .clk_i, .rst_ni,
    .hit_evt_i(hit_evt), .miss_evt_i(miss_evt),
    .hit_cnt_o, .miss_cnt_o
  );
endmodule

// File: tb/dm_cache_tb.sv
module dm_cache_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 15;
  localparam int DW = 12;
  localparam int IW = 9;
  localparam int CW = 16;
  localparam int NIDX = 1 << IW;

  logic          clk = 1'b0;
  logic          rst_ni, init_i, cpu_req_i, cpu_we_i;
  logic [AW-1:0] cpu_addr_i;
  logic [DW-1:0] cpu_wdata_i;
  logic          cpu_ready_o, cpu_valid_o;
  logic [DW-1:0] cpu_rdata_o;
  logic          mem_req_o, mem_we_o;
  logic [AW-1:0] mem_addr_o;
  logic [DW-1:0] mem_wdata_o;
  logic          mem_ack_i;
  logic [DW-1:0] mem_rdata_i;
  logic [CW-1:0] hit_cnt_o, miss_cnt_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  dm_cache u_dut (
    .clk_i(clk), .rst_ni, .init_i, .cpu_req_i, .cpu_we_i, .cpu_addr_i, .cpu_wdata_i,
    .cpu_ready_o, .cpu_valid_o, .cpu_rdata_o,
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o, .mem_ack_i, .mem_rdata_i,
    .hit_cnt_o, .miss_cnt_o
  );

  int n_tests = 0;
  int n_fail  = 0;

  task automatic check(bit ok, string req, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ---------------- main-memory model ----------------
  logic [DW-1:0] wmem [int];
  int mem_rd_cnt = 0, mem_wr_cnt = 0, last_mem_addr = -1, lat_sel = 0;

  function automatic logic [DW-1:0] mem_val(int a);
    if (wmem.exists(a)) return wmem[a];
    return DW'(a * 7 + 3);
  endfunction

  initial begin
    int wait_cnt;
    wait_cnt    = 0;
    mem_ack_i   = 1'b0;
    mem_rdata_i = '0;
    forever begin
      @(negedge clk);
      if (mem_req_o && !mem_ack_i) begin
        if (wait_cnt >= ((int'(mem_addr_o) + lat_sel) % 4)) begin
          mem_ack_i     = 1'b1;
          last_mem_addr = int'(mem_addr_o);
          if (mem_we_o) begin
            wmem[int'(mem_addr_o)] = mem_wdata_o;
            mem_wr_cnt++;
          end else begin
            mem_rdata_i = mem_val(int'(mem_addr_o));
            mem_rd_cnt++;
          end
          wait_cnt = 0;
        end else wait_cnt++;
      end else begin
        mem_ack_i = 1'b0;
        wait_cnt  = 0;
      end
    end
  end

  // ---------------- scoreboard ----------------
  typedef struct packed { logic we; logic [DW-1:0] data; } exp_t;
  exp_t exp_q[$];

  initial begin
    forever begin
      @(negedge clk);
      if (cpu_valid_o) begin
        if (exp_q.size() == 0) check(1'b0, "R9 completion without request", 1, 0);
        else begin
          exp_t e;
          e = exp_q.pop_front();
          if (!e.we) check(cpu_rdata_o == e.data, "R3 R4 read data", int'(cpu_rdata_o), int'(e.data));
        end
      end
    end
  end

  // ---------------- reference cache state ----------------
  bit            ref_v [NIDX];
  int            ref_t [NIDX];
  logic [DW-1:0] ref_d [NIDX];
  int exp_hits = 0, exp_miss = 0;
  logic [DW-1:0] last_rd;

  task automatic access(bit we, int a, logic [DW-1:0] wd);
    int idx, tg, rd0, wr0, cyc;
    bit h, rdy_bad;
    logic [DW-1:0] ed;
    idx = a % NIDX;
    tg  = a / NIDX;
    h   = ref_v[idx] && (ref_t[idx] == tg);
    ed  = h ? ref_d[idx] : mem_val(a);
    if (h) exp_hits++; else exp_miss++;
    if (we && h) ref_d[idx] = wd;
    if (!we && !h) begin
      ref_v[idx] = 1'b1; ref_t[idx] = tg; ref_d[idx] = ed;
    end
    exp_q.push_back('{we, ed});
    @(negedge clk);
    while (!cpu_ready_o) @(negedge clk);
    rd0 = mem_rd_cnt; wr0 = mem_wr_cnt;
    cpu_req_i = 1'b1; cpu_we_i = we; cpu_addr_i = AW'(a); cpu_wdata_i = wd;
    @(negedge clk);
    cpu_req_i = 1'b0;
    cyc = 1; rdy_bad = 1'b0;
    while (!cpu_valid_o && cyc < 100) begin
      if (cpu_ready_o) rdy_bad = 1'b1;
      @(negedge clk);
      cyc++;
    end
    last_rd = cpu_rdata_o;
    check(!rdy_bad && cpu_valid_o, "R9 ready low until completion", int'(rdy_bad), 0);
    if (!we && h) begin
      check(cyc == 2, "R3 hit latency", cyc, 2);
      check(mem_rd_cnt == rd0 && mem_wr_cnt == wr0, "R3 no memory traffic on hit",
            mem_rd_cnt - rd0 + mem_wr_cnt - wr0, 0);
    end
    if (!we && !h)
      check(mem_rd_cnt == rd0 + 1 && last_mem_addr == a, "R4 miss reads memory", last_mem_addr, a);
    if (we)
      check(mem_wr_cnt == wr0 + 1 && last_mem_addr == a && wmem[a] == wd, "R5 write-through",
            int'(wmem[a]), int'(wd));
    check(int'(hit_cnt_o) == exp_hits, "R10 hit count", int'(hit_cnt_o), exp_hits);
    check(int'(miss_cnt_o) == exp_miss, "R10 miss count", int'(miss_cnt_o), exp_miss);
  endtask

  task automatic pulse_init();
    @(negedge clk);
    init_i = 1'b1;
    @(negedge clk);
    init_i = 1'b0;
    for (int i = 0; i < NIDX; i++) ref_v[i] = 1'b0;
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #(CLK_PERIOD * 150000);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  // ---------------- stimulus ----------------
  initial begin
    int m0, h0;
    rst_ni = 1'b0; init_i = 1'b0; cpu_req_i = 1'b0; cpu_we_i = 1'b0;
    cpu_addr_i = '0; cpu_wdata_i = '0;
    for (int i = 0; i < NIDX; i++) begin ref_v[i] = 1'b0; ref_t[i] = 0; ref_d[i] = '0; end
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(cpu_ready_o && !cpu_valid_o && !mem_req_o, "R1 reset handshake",
          {cpu_ready_o, cpu_valid_o, mem_req_o}, 3'b100);
    check(hit_cnt_o == 0 && miss_cnt_o == 0, "R1 counters cleared", int'(hit_cnt_o + miss_cnt_o), 0);

    // R4 miss fill, R3 repeat hits
    access(1'b0, 'h0100, '0);
    access(1'b0, 'h0100, '0);
    access(1'b0, 'h0101, '0);

    // R2 same index, different tag evicts
    m0 = int'(miss_cnt_o);
    access(1'b0, 'h0100 | (1 << IW), '0);
    access(1'b0, 'h0100, '0);
    check(int'(miss_cnt_o) == m0 + 2, "R2 conflicting tags evict", int'(miss_cnt_o), m0 + 2);

    // R6 write hit refreshes cache
    lat_sel = 1;
    access(1'b1, 'h0100, 12'hA5C);
    h0 = int'(hit_cnt_o);
    access(1'b0, 'h0100, '0);
    check(int'(hit_cnt_o) == h0 + 1 && last_rd == 12'hA5C, "R6 write hit updates line",
          int'(last_rd), 'hA5C);

    // R7 write miss does not allocate
    access(1'b1, 'h2345, 12'h3C3);
    m0 = int'(miss_cnt_o);
    access(1'b0, 'h2345, '0);
    check(int'(miss_cnt_o) == m0 + 1 && last_rd == 12'h3C3, "R7 write miss not allocated",
          int'(last_rd), 'h3C3);

    // R8 init clears all valid flags
    access(1'b0, 'h0000, '0);
    access(1'b0, 'h7FFF, '0);
    pulse_init();
    m0 = int'(miss_cnt_o);
    access(1'b0, 'h0100, '0);
    access(1'b0, 'h0000, '0);
    access(1'b0, 'h7FFF, '0);
    check(int'(miss_cnt_o) == m0 + 3, "R8 init forces misses", int'(miss_cnt_o), m0 + 3);

    // R2 boundary: index 511 with tags 0 and 63
    access(1'b0, 'h01FF, '0);
    access(1'b0, 'h7FFF, '0);
    access(1'b0, 'h7FFF, '0);

    // mixed traffic over a small conflict-prone set
    for (int i = 0; i < 60; i++) begin
      lat_sel = i % 5;
      access((i % 7) == 3, ((i * 5) % 4) * NIDX + 5 + (i % 3), DW'(i * 91));
    end

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R9 every request completed", exp_q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule